// File: doc/BRIEF.md
# Bit-Field Clear and Insert Unit

This unit is a 32-bit datapath stage that edits a contiguous group of bits inside a destination word. It has two operations. The clear operation zeroes a run of bits. The insert operation overwrites that run with the lowest bits of a source word. The run is given by a starting bit position and a bit count, not by a mask.

Every request arrives with a valid strobe, a condition-pass qualifier, and a flag that marks a forbidden register choice. One clock later the unit presents a registered result, a write-enable and an illegal-encoding flag. Range checking of the position and count happens inside the unit. Register-file access and condition evaluation belong to the surrounding pipeline, and the unit never produces or alters processor status flags.

Top module: `bfu_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_result` is 0 and `out_wen` and `out_illegal` are both low.
- R2: A valid request is legal only when `in_lsb` is at most 31 and `in_width` is between 1 and 32 minus `in_lsb`, both limits included. For any other pair, the next cycle shows `out_illegal` = 1, `out_wen` = 0 and `out_result` = 0.
- R3: With `in_op` = 0 (clear), a legal written result equals `in_dst` with bits `in_lsb` through `in_lsb+in_width-1` forced to 0. Every other bit keeps its `in_dst` value.
- R4: With `in_op` = 1 (insert), a legal written result equals `in_dst` with bits `in_lsb` through `in_lsb+in_width-1` replaced by `in_src` bits 0 through `in_width-1`. Every other bit keeps its `in_dst` value.
- R5: For insert, `in_src` bits at or above position `in_width` have no effect on `out_result`.
- R6: When `in_lsb` = 0 and `in_width` = 32, clear yields 0 and insert yields `in_src`.
- R7: If `in_cond_pass` is low, `out_wen` stays 0 and `out_result` is 0. A legal request then leaves `out_illegal` at 0, and an illegal one still sets `out_illegal` to 1.
- R8: If `in_reg_bad` is high on a valid request, the next cycle shows `out_illegal` = 1 and `out_wen` = 0, whatever the position and count are.
- R9: All outputs are registered with exactly one cycle of latency. A cycle with `in_valid` low gives `out_wen` = 0, `out_illegal` = 0 and `out_result` = 0 in the next cycle.
- R10: Clearing with position 8 and count 12 zeroes bits 8 to 19. Inserting with the same values copies source bits 0 to 11 into bits 8 to 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 1 | 0 = clear, 1 = insert |
| in_dst | input | 32 | Word being edited |
| in_src | input | 32 | Bits inserted from bit 0 upward |
| in_lsb | input | 6 | Lowest bit of the field |
| in_width | input | 6 | Number of bits in the field |
| in_cond_pass | input | 1 | High when the request's condition holds |
| in_reg_bad | input | 1 | High when a forbidden register was named |
| out_result | output | 32 | Edited word, or 0 when no write takes place |
| out_wen | output | 1 | Write-enable for the result |
| out_illegal | output | 1 | Illegal-encoding flag |

## Verification
A faulty mask or merge shows up as a wrong bit in `out_result` exactly one cycle after the request. The bench sweeps every legal position and count pair with random words, so a mask that is off by one at any edge of the field, or a source bit that leaks in above the count, becomes visible within that sweep. A faulty legality decision appears in the same cycle as a mismatched `out_wen` or `out_illegal`. A full sweep of out-of-range pairs, plus the condition and forbidden-register cases, exposes such faults.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int DATA_W = 32;
    localparam int POS_W  = $clog2(DATA_W) + 1;

    typedef enum logic {
        BF_CLEAR  = 1'b0,
        BF_INSERT = 1'b1
    } bf_op_e;

    typedef struct packed {
        logic wen;
        logic illegal;
    } bf_status_t;

endpackage

// File: rtl/bfu_legal.sv
module bfu_legal #(
    parameter int DATA_W = bfu_pkg::DATA_W,
    parameter int POS_W  = bfu_pkg::POS_W
) (
    input  logic [POS_W-1:0] lsb_i,
    input  logic [POS_W-1:0] width_i,
    input  logic             reg_bad_i,
    output logic             legal_o
);
    localparam logic [POS_W:0] LIMIT = (POS_W+1)'(DATA_W);

    logic [POS_W:0] span_end;
    logic           pos_ok;
    logic           width_ok;

    always_comb begin
        span_end = {1'b0, lsb_i} + {1'b0, width_i};
        pos_ok   = ({1'b0, lsb_i} < LIMIT);
        width_ok = (width_i != '0) && (span_end <= LIMIT);
        legal_o  = !reg_bad_i && pos_ok && width_ok;
    end

    // R2: a legal decision never admits an empty field
    always_comb begin
        if (legal_o) begin
            assert_legal_nonempty_R2: assert (width_i != '0)
                else $error("legal request with empty field");
        end
    end
endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
    parameter int DATA_W = bfu_pkg::DATA_W,
    parameter int POS_W  = bfu_pkg::POS_W
) (
    input  logic [POS_W-1:0]  lsb_i,
    input  logic [POS_W-1:0]  width_i,
    output logic [DATA_W-1:0] mask_o
);
    localparam logic [POS_W-1:0] FULL = POS_W'(DATA_W);

    logic [DATA_W-1:0] low_ones;

    always_comb begin
        if (width_i >= FULL) low_ones = '1;
        else                 low_ones = (DATA_W'(1) << width_i) - DATA_W'(1);
        mask_o = low_ones << lsb_i;
    end

    // R3/R4: an in-range field yields exactly width ones starting at lsb
    always_comb begin
        if (width_i != '0 && (32'(lsb_i) + 32'(width_i)) <= DATA_W) begin
            assert_mask_count_R3: assert ($countones(mask_o) == 32'(width_i))
                else $error("mask population wrong");
            assert_mask_start_R4: assert (mask_o[lsb_i[POS_W-2:0]] == 1'b1)
                else $error("mask does not begin at lsb");
        end
    end
endmodule

// File: rtl/bfu_merge.sv
module bfu_merge #(
    parameter int DATA_W = bfu_pkg::DATA_W,
    parameter int POS_W  = bfu_pkg::POS_W
) (
    input  bfu_pkg::bf_op_e    op_i,
    input  logic [DATA_W-1:0]  dst_i,
    input  logic [DATA_W-1:0]  src_i,
    input  logic [POS_W-1:0]   lsb_i,
    input  logic [DATA_W-1:0]  mask_i,
    output logic [DATA_W-1:0]  result_o
);
    logic [DATA_W-1:0] kept;
    logic [DATA_W-1:0] placed;

    always_comb begin
        kept   = dst_i & ~mask_i;
        placed = (src_i << lsb_i) & mask_i;
        unique case (op_i)
            bfu_pkg::BF_CLEAR:  result_o = kept;
            bfu_pkg::BF_INSERT: result_o = kept | placed;
            default:            result_o = kept;
        endcase
    end

    // R3/R4: bits outside the field always pass through from dst
    always_comb begin
        assert_outside_kept_R4: assert (((result_o ^ dst_i) & ~mask_i) == '0)
            else $error("bit outside field altered");
        if (op_i == bfu_pkg::BF_CLEAR) begin
            assert_clear_zero_R3: assert ((result_o & mask_i) == '0)
                else $error("clear left a field bit set");
        end
    end
endmodule

// File: rtl/bfu_top.sv
module bfu_top #(
    parameter int DATA_W = bfu_pkg::DATA_W,
    parameter int POS_W  = bfu_pkg::POS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic [DATA_W-1:0] in_dst,
    input  logic [DATA_W-1:0] in_src,
    input  logic [POS_W-1:0]  in_lsb,
    input  logic [POS_W-1:0]  in_width,
    input  logic              in_cond_pass,
    input  logic              in_reg_bad,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wen,
    output logic              out_illegal
);
    import bfu_pkg::*;

    bf_op_e             op;
    logic               legal;
    logic [DATA_W-1:0]  mask;
    logic [DATA_W-1:0]  merged;
    bf_status_t         next_status;
    bf_status_t         status_q;
    logic [DATA_W-1:0]  result_q;

    assign op = bf_op_e'(in_op);

    bfu_legal #(.DATA_W(DATA_W), .POS_W(POS_W)) u_legal (
        .lsb_i     (in_lsb),
        .width_i   (in_width),
        .reg_bad_i (in_reg_bad),
        .legal_o   (legal)
    );

    bfu_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W)) u_mask (
        .lsb_i   (in_lsb),
        .width_i (in_width),
        .mask_o  (mask)
    );

    bfu_merge #(.DATA_W(DATA_W), .POS_W(POS_W)) u_merge (
        .op_i     (op),
        .dst_i    (in_dst),
        .src_i    (in_src),
        .lsb_i    (in_lsb),
        .mask_i   (mask),
        .result_o (merged)
    );

    always_comb begin
        next_status.wen     = in_valid && legal && in_cond_pass;
        next_status.illegal = in_valid && !legal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            result_q <= '0;
        end else begin
            status_q <= next_status;
            result_q <= next_status.wen ? merged : '0;
        end
    end

    assign out_wen     = status_q.wen;
    assign out_illegal = status_q.illegal;
    assign out_result  = result_q;

    // R7: a write needs a passing condition on a valid request
    assert_wen_cond_R7: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> $past(in_valid && in_cond_pass));

    // R2: write and illegal are never raised together
    assert_wen_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(out_wen && out_illegal));

    // R8: a forbidden register always reports illegal
    assert_bad_reg_R8: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_reg_bad) |-> (out_illegal && !out_wen));

    // R9: an idle cycle produces quiet outputs
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> (!out_wen && !out_illegal && out_result == '0));
endmodule

// File: tb/bfu_top_tb.sv
`timescale 1ns/1ps
module bfu_top_tb;
    localparam int DW = 32;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, in_op, in_cond_pass, in_reg_bad;
    logic [DW-1:0] in_dst, in_src;
    logic [PW-1:0] in_lsb, in_width;
    logic [DW-1:0] out_result;
    logic          out_wen, out_illegal;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    bfu_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src(in_src), .in_lsb(in_lsb), .in_width(in_width),
        .in_cond_pass(in_cond_pass), .in_reg_bad(in_reg_bad),
        .out_result(out_result), .out_wen(out_wen), .out_illegal(out_illegal)
    );

    function automatic bit ref_legal(int lsb, int w, bit bad);
        return !bad && lsb <= 31 && w >= 1 && w <= 32 - lsb;
    endfunction

    function automatic logic [DW-1:0] ref_field(bit op, logic [DW-1:0] d,
                                                logic [DW-1:0] s, int lsb, int w);
        logic [DW-1:0] r = d;
        for (int i = 0; i < DW; i++)
            if (i >= lsb && i < lsb + w) r[i] = op ? s[i-lsb] : 1'b0;
        return r;
    endfunction

    task automatic check(string tag, logic [DW-1:0] er, bit ew, bit ei);
        vectors++;
        if (out_result !== er || out_wen !== ew || out_illegal !== ei) begin
            fails++;
            $display("FAIL %s: got result=%h wen=%b ill=%b, expected result=%h wen=%b ill=%b",
                     tag, out_result, out_wen, out_illegal, er, ew, ei);
        end
    endtask

    task automatic apply(string tag, bit op, logic [DW-1:0] d, logic [DW-1:0] s,
                         int lsb, int w, bit cond, bit bad);
        bit lg, ew;
        @(negedge clk);
        in_valid = 1; in_op = op; in_dst = d; in_src = s;
        in_lsb = PW'(lsb); in_width = PW'(w); in_cond_pass = cond; in_reg_bad = bad;
        @(negedge clk);
        lg = ref_legal(lsb, w, bad);
        ew = lg && cond;
        check(tag, ew ? ref_field(op, d, s, lsb, w) : '0, ew, !lg);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        in_valid = 0; in_dst = $urandom; in_src = $urandom;
        in_lsb = 6'd63; in_width = 6'd0; in_reg_bad = 1; in_cond_pass = 1;
        @(negedge clk);
        check(tag, '0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h1f2e3d4c));
        rst = 1; in_valid = 0; in_op = 0; in_dst = '1; in_src = '1;
        in_lsb = 0; in_width = 0; in_cond_pass = 1; in_reg_bad = 0;
        repeat (3) @(negedge clk);
        check("R1 during reset", '0, 0, 0);
        rst = 0;
        @(negedge clk);
        check("R1 after release", '0, 0, 0);

        // R10 directed examples
        apply("R10 clear 8/12", 0, 32'hFFFF_FFFF, 32'h0, 8, 12, 1, 0);
        apply("R10 insert 8/12", 1, 32'h1234_5678, 32'hABCD_E9A5, 8, 12, 1, 0);
        // R6 full-word field
        apply("R6 clear full", 0, 32'hDEAD_BEEF, 32'h1, 0, 32, 1, 0);
        apply("R6 insert full", 1, 32'hDEAD_BEEF, 32'hCAFE_F00D, 0, 32, 1, 0);
        // R5 high source bits must not leak
        apply("R5 src high bits", 1, 32'h0, 32'hFFFF_FFF0, 4, 4, 1, 0);
        apply("R5 top bit field", 1, 32'h0, 32'hFFFF_FFFE, 31, 1, 1, 0);
        // R7 condition fail, legal and illegal
        apply("R7 cond low legal", 1, 32'h5555_5555, 32'hFFFF_FFFF, 3, 7, 0, 0);
        apply("R7 cond low illegal", 0, 32'h5555_5555, 32'h0, 30, 5, 0, 0);
        // R8 forbidden register
        apply("R8 bad reg", 1, 32'h1, 32'h2, 0, 8, 1, 1);
        apply("R8 bad reg cond low", 0, 32'h1, 32'h2, 0, 8, 0, 1);
        // R9 idle and back-to-back
        idle("R9 idle");
        apply("R9 after idle", 0, 32'hF0F0_F0F0, 32'h0, 0, 4, 1, 0);
        idle("R9 idle again");

        // R3 / R4 exhaustive legal sweep with random words
        for (int lsb = 0; lsb < 32; lsb++)
            for (int w = 1; w <= 32 - lsb; w++) begin
                apply("R3 clear sweep", 0, $urandom, $urandom, lsb, w, 1, 0);
                apply("R4 insert sweep", 1, $urandom, $urandom, lsb, w, 1, 0);
            end

        // R2 every illegal pair in the 6-bit operand space
        for (int lsb = 0; lsb < 64; lsb++)
            for (int w = 0; w < 64; w++)
                if (!ref_legal(lsb, w, 0))
                    apply("R2 illegal pair", 1'($urandom), $urandom, $urandom, lsb, w,
                          1'($urandom), 0);

        // mixed random including condition and register flags
        for (int k = 0; k < 500; k++)
            apply("R7 random mix", 1'($urandom), $urandom, $urandom,
                  int'($urandom_range(0, 40)), int'($urandom_range(0, 40)),
                  ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule